// File: doc/BRIEF.md
# Card Clock Divider Generator

This block derives the clock that drives a memory-card bus from a faster master clock. A control word selects an 8-bit divide value and one of two ratio formulas. One formula gives only even ratios with a symmetric waveform. The other gives any integer ratio from 2 upward. The control word also holds a run enable, a pass-through (bypass) request, an idle power-save request, a flow-control enable and two bus-width select bits. The width selects are decoded into a compact width code for the neighbouring data path.

The data path reports whether a transfer is active, its direction, and the fill state of its queues. When flow control is enabled, the card clock is frozen low whenever the card would otherwise push data into a full receive queue or pull data from an empty transmit queue. Every stop finishes the running high phase first. Every divide-setting change waits for the start of a new period. As a result the card never sees a shortened pulse.

Top module: `cclk_gen`

## Requirements
- R1: With the formula-select bit clear, the divide value d (control bits 7:0) gives a card clock period of 2*(d+1) master cycles, with d+1 cycles high and d+1 cycles low. This covers d=0 through d=255.
- R2: With the formula-select bit set, the period is d+2 master cycles: floor((d+2)/2) high and ceil((d+2)/2) low.
- R3: While the run-enable bit (bit 8) is clear, and throughout reset, the card clock stays low. After the enable is set again, once the low phase has lasted its full length, the clock rises on the next master edge.
- R4: With the bypass bit (bit 10) set and the clock allowed to run, the card clock equals the master clock. With bypass set and the enable clear, it stays low. Clearing bypass returns to divided operation.
- R5: With the power-save bit (bit 9) set, the clock is held low while bus_idle is high and resumes on the next edge after bus_idle falls. With power-save clear, bus_idle has no effect on the waveform.
- R6: With the flow-control bit set and xfer_active high, the clock is held low during a write (xfer_write=1) while txq_empty is high, and during a read (xfer_write=0) while rxq_full is high. It rises on the next master edge after the condition clears. The queue flag of the opposite direction, and all flags when flow control is clear, have no effect.
- R7: A new divide value or formula written while the clock runs leaves the current high phase and the following low phase at their old lengths. It applies from the next rising edge.
- R8: bus_width is 2 when the 8-bit select (bit 12) is set, 1 when only the 4-bit select (bit 11) is set, and 0 otherwise. It never takes the value 3.
- R9: Parameter FLOW_BIT places the flow-control bit at 13 or 14. The formula-select bit takes whichever of the two positions is left.
- R10: A stop request (enable, power-save or flow control) never truncates a high phase. The high phase always lasts its full length, and each rising edge happens only when the clock was allowed to run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 15 | Divide value, enable, power-save, bypass, width selects, flow-control and formula bits |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_write | input | 1 | Transfer direction: 1 towards the card, 0 from the card |
| txq_empty | input | 1 | Transmit queue holds no data |
| rxq_full | input | 1 | Receive queue has no free space |
| bus_idle | input | 1 | Card bus has no command or data activity |
| card_clk | output | 1 | Generated card clock |
| bus_width | output | 2 | Width code: 0 one line, 1 four lines, 2 eight lines |

## Verification
The bound checker watches the divided waveform on every cycle. It checks that each high phase matches the length given by the captured setting, and that each low phase lasts at least its minimum. It also checks that a rise occurs only when running is allowed, that the captured setting moves only at a rising edge, that pass-through and the divider never drive at the same time, and that the width code is never 3. Only the bench scenarios can show the externally visible effects. These are the exact periods for chosen divide values, the one-edge resume after a stall or idle period clears, and the master clock appearing at the pin in bypass. They also include the opposite-direction queue flag being ignored and the alternate flow-bit placement.

// File: rtl/cclk_pkg.sv
package cclk_pkg;

    localparam int DIV_W     = 8;
    localparam int CNT_W     = DIV_W + 1;
    localparam int CTRL_W    = 15;
    localparam int EN_BIT    = 8;
    localparam int PSAVE_BIT = 9;
    localparam int BYP_BIT   = 10;
    localparam int W4_BIT    = 11;
    localparam int W8_BIT    = 12;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        BW_ONE   = 2'd0,
        BW_FOUR  = 2'd1,
        BW_EIGHT = 2'd2
    } bw_e;

    typedef enum logic {
        FORM_EVEN = 1'b0,
        FORM_ANY  = 1'b1
    } form_e;

    // Settings that shape one period of the divided clock.
    typedef struct packed {
        div_t  div;
        form_e form;
    } act_t;

    // Fully decoded control word.
    typedef struct packed {
        act_t  shape;
        logic  en;
        logic  psave;
        logic  byp;
        logic  flow;
        bw_e   width;
    } cfg_t;

    function automatic cnt_t high_len(div_t d, form_e f);
        cnt_t p;
        cnt_t r;
        if (f == FORM_EVEN) begin
            r = cnt_t'(d) + cnt_t'(1);
        end else begin
            p = cnt_t'(d) + cnt_t'(2);
            r = p >> 1;
        end
        return r;
    endfunction

    function automatic cnt_t low_len(div_t d, form_e f);
        cnt_t p;
        cnt_t r;
        if (f == FORM_EVEN) begin
            r = cnt_t'(d) + cnt_t'(1);
        end else begin
            p = cnt_t'(d) + cnt_t'(2);
            r = p - (p >> 1);
        end
        return r;
    endfunction

    function automatic bw_e width_code(logic w4, logic w8);
        bw_e r;
        if (w8)      r = BW_EIGHT;
        else if (w4) r = BW_FOUR;
        else         r = BW_ONE;
        return r;
    endfunction

endpackage

// File: rtl/cclk_decode.sv
module cclk_decode
    import cclk_pkg::*;
#(
    parameter int FLOW_BIT = 13
) (
    input  logic [CTRL_W-1:0] ctrl,
    output cfg_t              cfg
);

    logic flow_sel;
    logic form_sel;

    // The flow-control bit and the formula bit share positions 13 and 14.
    if (FLOW_BIT == 13) begin : g_flow_low
        assign flow_sel = ctrl[13];
        assign form_sel = ctrl[14];
    end else begin : g_flow_high
        assign flow_sel = ctrl[14];
        assign form_sel = ctrl[13];
    end

    always_comb begin
        cfg.shape.div  = ctrl[DIV_W-1:0];
        cfg.shape.form = form_sel ? FORM_ANY : FORM_EVEN;
        cfg.en         = ctrl[EN_BIT];
        cfg.psave      = ctrl[PSAVE_BIT];
        cfg.byp        = ctrl[BYP_BIT];
        cfg.flow       = flow_sel;
        cfg.width      = width_code(ctrl[W4_BIT], ctrl[W8_BIT]);
    end

endmodule

// File: rtl/cclk_run.sv
module cclk_run (
    input  logic en,
    input  logic psave,
    input  logic flow,
    input  logic xfer_active,
    input  logic xfer_write,
    input  logic txq_empty,
    input  logic rxq_full,
    input  logic bus_idle,
    output logic run
);

    logic q_blocked;
    logic stall;
    logic idle_stop;

    always_comb begin
        q_blocked = xfer_write ? txq_empty : rxq_full;
        stall     = flow & xfer_active & q_blocked;
        idle_stop = psave & bus_idle;
        run       = en & ~stall & ~idle_stop;
    end

endmodule

// File: rtl/cclk_core.sv
module cclk_core
    import cclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic byp_req,
    input  act_t nxt,
    output logic div_q,
    output logic byp_act,
    output act_t act
);

    cnt_t ph_cnt;
    cnt_t hi_len;
    cnt_t lo_len;
    logic hi_done;
    logic lo_done;

    always_comb begin
        hi_len  = high_len(act.div, act.form);
        lo_len  = low_len(act.div, act.form);
        hi_done = (ph_cnt == hi_len - cnt_t'(1));
        lo_done = (ph_cnt >= lo_len - cnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q    <= 1'b0;
            byp_act  <= 1'b0;
            ph_cnt   <= '0;
            act.div  <= '0;
            act.form <= FORM_EVEN;
        end else if (div_q) begin
            // High phase always runs to its full length.
            if (hi_done) begin
                div_q  <= 1'b0;
                ph_cnt <= '0;
            end else begin
                ph_cnt <= ph_cnt + cnt_t'(1);
            end
        end else if (lo_done) begin
            // Low phase complete: safe point for mode and setting changes.
            byp_act <= byp_req;
            if (run && !byp_req) begin
                div_q  <= 1'b1;
                ph_cnt <= '0;
                act    <= nxt;
            end
        end else begin
            ph_cnt <= ph_cnt + cnt_t'(1);
        end
    end

endmodule

// File: rtl/cclk_bypass.sv
module cclk_bypass (
    input  logic clk,
    input  logic rst,
    input  logic byp_act,
    input  logic run,
    input  logic div_q,
    output logic card_clk
);

    logic gate_q;

    // Gate moves only while the master clock is low, so no partial pulse.
    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= byp_act & run;
    end

    assign card_clk = div_q | (clk & gate_q);

endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
    import cclk_pkg::*;
#(
    parameter int FLOW_BIT = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              xfer_active,
    input  logic              xfer_write,
    input  logic              txq_empty,
    input  logic              rxq_full,
    input  logic              bus_idle,
    output logic              card_clk,
    output logic [1:0]        bus_width
);

    cfg_t cfg;
    logic run;
    logic div_q;
    logic byp_act;
    act_t act;

    cclk_decode #(.FLOW_BIT(FLOW_BIT)) u_decode (
        .ctrl (ctrl_word),
        .cfg  (cfg)
    );

    cclk_run u_run (
        .en          (cfg.en),
        .psave       (cfg.psave),
        .flow        (cfg.flow),
        .xfer_active (xfer_active),
        .xfer_write  (xfer_write),
        .txq_empty   (txq_empty),
        .rxq_full    (rxq_full),
        .bus_idle    (bus_idle),
        .run         (run)
    );

    cclk_core u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .byp_req (cfg.byp),
        .nxt     (cfg.shape),
        .div_q   (div_q),
        .byp_act (byp_act),
        .act     (act)
    );

    cclk_bypass u_byp (
        .clk      (clk),
        .rst      (rst),
        .byp_act  (byp_act),
        .run      (run),
        .div_q    (div_q),
        .card_clk (card_clk)
    );

    assign bus_width = cfg.width;

endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk
    import cclk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       div_q,
    input logic       byp_act,
    input logic       run,
    input act_t       act,
    input logic [1:0] bus_width
);

    localparam int RUN_W = CNT_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] hi_run;
    logic [RUN_W-1:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= div_q ? hi_run + 1'b1 : '0;
            if (div_q)                lo_run <= '0;
            else if (lo_run != RUN_MAX) lo_run <= lo_run + 1'b1;
        end
    end

    // R1 R2 R10: every completed high phase has the length of the captured setting
    a_r10_full_high: assert property (@(posedge clk) disable iff (rst)
        $fell(div_q) |-> hi_run == {1'b0, high_len(act.div, act.form)});

    // R1 R2: a low phase is never shorter than its setting
    a_r2_low_min: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> lo_run >= {1'b0, low_len($past(act.div), $past(act.form))});

    // R3 R5 R6: a rising edge only when running is allowed
    a_r6_rise_when_run: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> $past(run));

    // R7: captured settings move only at the start of a period
    a_r7_setting_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(div_q) |-> ($stable(act.div) && $stable(act.form)));

    // R4: pass-through and divider never drive together
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        byp_act |-> !div_q);

    // R8: width code 3 is never produced
    a_r8_width_code: assert property (@(posedge clk) disable iff (rst)
        bus_width != 2'd3);

endmodule

bind cclk_gen cclk_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_q     (div_q),
    .byp_act   (byp_act),
    .run       (run),
    .act       (act),
    .bus_width (bus_width)
);

// File: tb/cclk_gen_test.sv
module cclk_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ctrl_a = '0;
    logic [14:0] ctrl_b = '0;
    logic        xfer_active = 1'b0;
    logic        xfer_write = 1'b0;
    logic        txq_empty = 1'b0;
    logic        rxq_full = 1'b0;
    logic        bus_idle = 1'b0;
    logic        cclk_a, cclk_b;
    logic [1:0]  bw_a, bw_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cclk_gen #(.FLOW_BIT(13)) uut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_a), .xfer_active(xfer_active),
        .xfer_write(xfer_write), .txq_empty(txq_empty), .rxq_full(rxq_full),
        .bus_idle(bus_idle), .card_clk(cclk_a), .bus_width(bw_a));

    cclk_gen #(.FLOW_BIT(14)) uut_b (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_b), .xfer_active(xfer_active),
        .xfer_write(xfer_write), .txq_empty(txq_empty), .rxq_full(rxq_full),
        .bus_idle(bus_idle), .card_clk(cclk_b), .bus_width(bw_b));

    function automatic logic [14:0] mk(int d, bit en, bit ps, bit byp, bit w4, bit w8,
                                       bit flow, bit alt, bit fb13);
        logic [14:0] w;
        w = '0;
        w[7:0] = d[7:0];
        w[8] = en; w[9] = ps; w[10] = byp; w[11] = w4; w[12] = w8;
        if (fb13) begin w[13] = flow; w[14] = alt; end
        else      begin w[14] = flow; w[13] = alt; end
        return w;
    endfunction

    function automatic int exp_hi(int d, bit alt);
        return alt ? (d + 2) / 2 : d + 1;
    endfunction

    function automatic int exp_lo(int d, bit alt);
        return alt ? (d + 3) / 2 : d + 1;
    endfunction

    function automatic bit cc(bit which);
        return which ? cclk_b : cclk_a;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_rise(input bit which);
        bit p;
        p = cc(which);
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (!p && cc(which)) break;
            p = cc(which);
        end
    endtask

    task automatic meas(input bit which, output int hi, output int lo);
        wait_rise(which);
        hi = 1;
        lo = 0;
        tick();
        for (int i = 0; i < 3000 && cc(which); i++) begin hi++; tick(); end
        for (int i = 0; i < 3000 && !cc(which); i++) begin lo++; tick(); end
    endtask

    task automatic check_period(input int d, input bit alt, input string tag);
        int hi, lo;
        ctrl_a = mk(d, 1, 0, 0, 0, 0, 0, alt, 1);
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk(hi == exp_hi(d, alt), tag, hi, exp_hi(d, alt));
        chk(lo == exp_lo(d, alt), tag, lo, exp_lo(d, alt));
    endtask

    task automatic check_low(input bit which, input int n, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (cc(which)) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi, lo, hi2, d;
        void'($urandom(32'd2024));

        // R3: reset state
        repeat (4) tick();
        chk(cclk_a == 1'b0, "R3 reset clock low", cclk_a, 0);
        chk(bw_a == 2'd0, "R8 reset width", bw_a, 0);
        rst = 1'b0;
        check_low(0, 10, "R3 disabled after reset");

        // R1: standard formula, corners and random
        check_period(0, 0, "R1 std d=0");
        check_period(255, 0, "R1 std d=255");
        for (int k = 0; k < 6; k++) check_period(int'($urandom % 24), 0, "R1 std random");

        // R2: any-ratio formula, corners and random
        check_period(0, 1, "R2 alt d=0");
        check_period(1, 1, "R2 alt d=1");
        check_period(255, 1, "R2 alt d=255");
        for (int k = 0; k < 6; k++) check_period(int'($urandom % 24), 1, "R2 alt random");

        // R10 and R3: stop during a high phase, then resume
        ctrl_a = mk(5, 1, 0, 0, 0, 0, 0, 0, 1);
        meas(0, hi, lo);
        ctrl_a = mk(5, 0, 0, 0, 0, 0, 0, 0, 1);
        hi = 1;
        tick();
        for (int i = 0; i < 100 && cclk_a; i++) begin hi++; tick(); end
        chk(hi == 6, "R10 high not truncated", hi, 6);
        check_low(0, 40, "R3 enable clear holds low");
        ctrl_a = mk(5, 1, 0, 0, 0, 0, 0, 0, 1);
        tick();
        chk(cclk_a == 1'b1, "R3 resume next edge", cclk_a, 1);

        // R5: power-save
        ctrl_a = mk(2, 1, 1, 0, 0, 0, 0, 0, 1);
        bus_idle = 1'b1;
        repeat (10) tick();
        check_low(0, 30, "R5 idle holds low");
        bus_idle = 1'b0;
        tick();
        chk(cclk_a == 1'b1, "R5 resume after idle", cclk_a, 1);
        ctrl_a = mk(2, 1, 0, 0, 0, 0, 0, 0, 1);
        bus_idle = 1'b1;
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk(hi == 3 && lo == 3, "R5 idle ignored without power-save", hi * 10 + lo, 33);
        bus_idle = 1'b0;

        // R6: flow control
        ctrl_a = mk(1, 1, 0, 0, 0, 0, 1, 0, 1);
        xfer_active = 1'b1;
        xfer_write = 1'b1;
        txq_empty = 1'b1;
        repeat (10) tick();
        check_low(0, 20, "R6 write stall");
        txq_empty = 1'b0;
        tick();
        chk(cclk_a == 1'b1, "R6 write resume next edge", cclk_a, 1);
        xfer_write = 1'b0;
        rxq_full = 1'b1;
        repeat (10) tick();
        check_low(0, 20, "R6 read stall");
        rxq_full = 1'b0;
        tick();
        chk(cclk_a == 1'b1, "R6 read resume next edge", cclk_a, 1);
        txq_empty = 1'b1;
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk(hi == 2 && lo == 2, "R6 opposite flag ignored", hi * 10 + lo, 22);
        xfer_write = 1'b1;
        ctrl_a = mk(1, 1, 0, 0, 0, 0, 0, 0, 1);
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk(hi == 2 && lo == 2, "R6 flow disabled ignored", hi * 10 + lo, 22);
        txq_empty = 1'b0;
        xfer_active = 1'b0;

        // R7: change inside a period
        ctrl_a = mk(3, 1, 0, 0, 0, 0, 0, 0, 1);
        meas(0, hi, lo);
        meas(0, hi, lo);
        ctrl_a = mk(9, 1, 0, 0, 0, 0, 0, 0, 1);
        hi = 1;
        lo = 0;
        hi2 = 0;
        tick();
        for (int i = 0; i < 100 && cclk_a; i++) begin hi++; tick(); end
        for (int i = 0; i < 100 && !cclk_a; i++) begin lo++; tick(); end
        for (int i = 0; i < 100 && cclk_a; i++) begin hi2++; tick(); end
        chk(hi == 4, "R7 current high keeps old length", hi, 4);
        chk(lo == 4, "R7 following low keeps old length", lo, 4);
        chk(hi2 == 10, "R7 new length from next rise", hi2, 10);

        // R4: bypass
        ctrl_a = mk(3, 1, 0, 1, 0, 0, 0, 0, 1);
        repeat (30) tick();
        d = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #2;
            if (cclk_a !== 1'b1) d++;
            #5;
            if (cclk_a !== 1'b0) d++;
        end
        chk(d == 0, "R4 bypass follows master", d, 0);
        ctrl_a = mk(3, 0, 0, 1, 0, 0, 0, 0, 1);
        repeat (5) tick();
        d = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #2;
            if (cclk_a !== 1'b0) d++;
            #5;
            if (cclk_a !== 1'b0) d++;
        end
        chk(d == 0, "R4 bypass disabled low", d, 0);
        ctrl_a = mk(0, 1, 0, 0, 0, 0, 0, 0, 1);
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk(hi == 1 && lo == 1, "R4 return to divided", hi * 10 + lo, 11);

        // R8: width code
        for (int w = 0; w < 4; w++) begin
            ctrl_a = mk(0, 1, 0, 0, w[0], w[1], 0, 0, 1);
            #1;
            d = w[1] ? 2 : (w[0] ? 1 : 0);
            chk(bw_a == d[1:0], "R8 width code", bw_a, d);
        end

        // R9: alternate bit placement on the second instance
        ctrl_b = mk(3, 1, 0, 0, 0, 0, 0, 1, 0);
        meas(1, hi, lo);
        meas(1, hi, lo);
        chk(hi == 2 && lo == 3, "R9 formula bit at 13", hi * 10 + lo, 23);
        ctrl_b = mk(3, 1, 0, 0, 0, 0, 1, 1, 0);
        xfer_active = 1'b1;
        xfer_write = 1'b1;
        txq_empty = 1'b1;
        repeat (10) tick();
        check_low(1, 20, "R9 flow bit at 14 stalls");
        xfer_active = 1'b0;
        txq_empty = 1'b0;
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule